// File: doc/BRIEF.md
# UART Receive Queue with Fill Trigger and Idle Timeout

This block sits between a serial receiver's bit sampler and the software-facing side of a UART. Each character the sampler finishes arrives as a one-cycle valid strobe with eight data bits and three tags: parity error, framing error and break. The block holds up to 32 such characters in arrival order. The oldest one is always visible on the read port, and a read strobe removes it.

Two interrupt sources tell software when to drain the queue. A fill interrupt asserts while the number of held characters is at or above a level chosen by a small code. An idle interrupt asserts once characters have sat unread, with nothing new arriving, for a programmed number of bit times. The bit times are counted from a one-cycle tick supplied by the baud generator.

Sticky status bits record tagged characters and lost characters until software clears them by writing ones. A flush strobe drops the whole contents of the queue at once.

Top module: `uart_rx_queue`

## Requirements
- R1: The queue holds up to 32 characters. `rd_data` and the head tags always show the oldest held character. An accepted `char_valid` raises `st_level` by one on the next cycle and an accepted `rd_en` lowers it by one; when both are accepted in the same cycle the level is unchanged. `st_empty` is high when the level is 0 and `st_full` is high when it is 32.
- R2: A character that arrives while the queue is full is discarded, and `st_err[3]` (overflow) sets. A read in that same cycle does not make room for the arriving character.
- R3: `rd_en` while the queue is empty has no effect on the level or on the contents.
- R4: The fill trigger code maps 0→1, 1→4, 2→8, 3→14 and 4→30 characters, and every code from 5 to 15 also means 30. `irq_rda` is high exactly when `cfg_rda_ie` is 1 and `st_level` is at or above the selected level.
- R5: The tags of each accepted character are stored with it and shown on `rd_perr`, `rd_ferr` and `rd_brk` while that character is at the head. An accepted character carrying a tag sets the matching sticky bit: `st_err[0]` for parity, `st_err[1]` for framing, `st_err[2]` for break.
- R6: A 1 in bit n of `err_clr` clears `st_err[n]` on the next cycle. If that bit is being set in the same cycle, setting wins.
- R7: The idle counter advances on each `bit_tick` while the queue is non-empty and `cfg_tout_cnt_en` is 1. The idle flag sets on the tick that brings the count to `cfg_tout_limit`; a limit of 0 sets it on the first tick. `irq_tout` is high when the flag is set and `cfg_tout_ie` is 1.
- R8: The idle counter restarts from zero on every accepted character and on every accepted read. An arrival leaves an already-set idle flag standing. An accepted read, or the queue being empty, clears the flag.
- R9: While `cfg_tout_cnt_en` is 0 the counter stays at zero and the idle flag never sets.
- R10: `flush` empties the queue and clears the idle flag and counter. A character or read in the same cycle is ignored. The sticky error bits are not changed by a flush.
- R11: After reset the queue is empty, all sticky bits are 0 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One pulse per serial bit time |
| char_valid | input | 1 | A received character is presented this cycle |
| char_data | input | 8 | Received character |
| char_perr | input | 1 | Parity error tag of the character |
| char_ferr | input | 1 | Framing error tag of the character |
| char_brk | input | 1 | Break tag of the character |
| rd_en | input | 1 | Remove the head character |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Parity tag of the head character |
| rd_ferr | output | 1 | Framing tag of the head character |
| rd_brk | output | 1 | Break tag of the head character |
| flush | input | 1 | Empty the queue |
| err_clr | input | 4 | Write-one-to-clear strobes for `st_err` |
| cfg_trig_code | input | 4 | Fill trigger level code |
| cfg_rda_ie | input | 1 | Fill interrupt enable |
| cfg_tout_ie | input | 1 | Idle interrupt enable |
| cfg_tout_cnt_en | input | 1 | Idle counter enable |
| cfg_tout_limit | input | 8 | Idle period in bit times |
| st_empty | output | 1 | Queue empty |
| st_full | output | 1 | Queue full |
| st_level | output | 6 | Number of held characters |
| st_err | output | 4 | Sticky bits: overflow, break, framing, parity (bit 3 down to 0) |
| irq_rda | output | 1 | Fill level interrupt |
| irq_tout | output | 1 | Idle timeout interrupt |

## Verification
The bench builds the block with its defaults: a depth of 32 and an 8-bit idle limit. At that depth the 30-character trigger, the full boundary and the overflow-with-read case can all be reached in a few dozen cycles. Idle limits are kept between 0 and 6 so that the timeout boundary, including the zero-limit case, is crossed many times. Random phases alternate between write-heavy and read-heavy traffic so that the level sweeps between empty and full.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Sticky status bit positions.
  localparam int ERR_PAR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_BRK = 2;
  localparam int ERR_OVF = 3;
  localparam int ERR_N   = 4;

  // Fill trigger code to character count; codes past the last listed one saturate.
  function automatic logic [5:0] trig_bytes(input logic [3:0] code);
    logic [5:0] n;
    case (code)
      4'd0:    n = 6'd1;
      4'd1:    n = 6'd4;
      4'd2:    n = 6'd8;
      4'd3:    n = 6'd14;
      default: n = 6'd30;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 11,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [LVL_W-1:0] level_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level_q == '0);
  assign full    = (32'(level_q) == DEPTH);
  // Fullness is judged before any read of the same cycle.
  assign push_ok = push & ~full & ~flush;
  assign drop    = push &  full & ~flush;
  assign pop_ok  = pop  & ~empty & ~flush;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else if (flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      level_q <= level_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end
  end

  assign rdata = mem[rd_ptr];
  assign level = level_q;
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_en,
  input  logic          busy,
  input  logic          restart,
  input  logic          drop_flag,
  input  logic [TW-1:0] limit,
  output logic          flag,
  output logic          hit
);
  logic [TW-1:0] cnt;
  logic [TW:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt} + (TW+1)'(1);
  // The tick that brings the count to the limit raises the flag.
  assign hit = cnt_en & busy & tick & ~flag & ~restart & (cnt_nx >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (restart | ~busy | ~cnt_en) cnt <= '0;
      else if (tick & ~flag)         cnt <= cnt_nx[TW-1:0];

      if (drop_flag) flag <= 1'b0;
      else if (hit)  flag <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_sticky.sv
module rxq_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        r <= 1'b0;
      else if (set_i[i]) r <= 1'b1;
      else if (clr_i[i]) r <= 1'b0;
    end
    assign flags_o[i] = r;
  end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int TOUT_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              char_brk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              rd_brk,
  input  logic              flush,
  input  logic [ERR_N-1:0]  err_clr,
  input  logic [3:0]        cfg_trig_code,
  input  logic              cfg_rda_ie,
  input  logic              cfg_tout_ie,
  input  logic              cfg_tout_cnt_en,
  input  logic [TOUT_W-1:0] cfg_tout_limit,
  output logic              st_empty,
  output logic              st_full,
  output logic [LVL_W-1:0]  st_level,
  output logic [ERR_N-1:0]  st_err,
  output logic              irq_rda,
  output logic              irq_tout
);
  localparam int W  = DATA_W + 3;
  localparam int CW = (LVL_W > 6) ? LVL_W : 6;

  // Internal events, named for the bound checker.
  logic             push_ok;
  logic             pop_ok;
  logic             drop;
  logic             tout_flag;
  logic             tout_hit;
  logic             lvl_hit;
  logic [W-1:0]     wr_word;
  logic [W-1:0]     head_word;
  logic [ERR_N-1:0] err_set;
  logic [CW-1:0]    lvl_x;
  logic [CW-1:0]    trig_x;

  assign wr_word = {char_brk, char_ferr, char_perr, char_data};

  rxq_store #(
    .DEPTH (DEPTH),
    .WIDTH (W),
    .LVL_W (LVL_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .push    (char_valid),
    .pop     (rd_en),
    .wdata   (wr_word),
    .rdata   (head_word),
    .level   (st_level),
    .empty   (st_empty),
    .full    (st_full),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .drop    (drop)
  );

  assign {rd_brk, rd_ferr, rd_perr, rd_data} = head_word;

  rxq_idle_timer #(
    .TW (TOUT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bit_tick),
    .cnt_en    (cfg_tout_cnt_en),
    .busy      (!st_empty),
    .restart   (push_ok | pop_ok | flush),
    .drop_flag (pop_ok | flush | st_empty),
    .limit     (cfg_tout_limit),
    .flag      (tout_flag),
    .hit       (tout_hit)
  );

  always_comb begin
    err_set          = '0;
    err_set[ERR_PAR] = push_ok & char_perr;
    err_set[ERR_FRM] = push_ok & char_ferr;
    err_set[ERR_BRK] = push_ok & char_brk;
    err_set[ERR_OVF] = drop;
  end

  rxq_sticky #(
    .N (ERR_N)
  ) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (err_set),
    .clr_i   (err_clr),
    .flags_o (st_err)
  );

  assign lvl_x    = CW'(st_level);
  assign trig_x   = CW'(trig_bytes(cfg_trig_code));
  assign lvl_hit  = (lvl_x >= trig_x);
  assign irq_rda  = cfg_rda_ie & lvl_hit;
  assign irq_tout = cfg_tout_ie & tout_flag;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DEPTH = 32,
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             char_valid,
  input logic             char_perr,
  input logic [3:0]       err_clr,
  input logic             push_ok,
  input logic             pop_ok,
  input logic             drop,
  input logic             tout_hit,
  input logic             cfg_rda_ie,
  input logic             cfg_tout_cnt_en,
  input logic [LVL_W-1:0] st_level,
  input logic             st_empty,
  input logic             st_full,
  input logic [3:0]       st_err,
  input logic             irq_rda,
  input logic             irq_tout
);
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(st_level) <= DEPTH);

  a_r1_level_up: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !pop_ok |=> st_level == LVL_W'($past(st_level) + 1'b1));

  a_r2_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> st_err[3]);

  a_r2_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> st_full);

  a_r3_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty && !char_valid |=> st_empty);

  a_r4_rda_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rda |-> cfg_rda_ie && !st_empty);

  a_r6_par_clear: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr[0] && !(push_ok && char_perr) |=> !st_err[0]);

  a_r7_tout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tout |-> !st_empty);

  a_r9_no_hit_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tout_cnt_en |-> !tout_hit);

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> st_empty && !irq_tout);
endmodule

bind uart_rx_queue uart_rx_queue_chk #(
  .DEPTH (DEPTH),
  .LVL_W ($clog2(DEPTH + 1))
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .flush           (flush),
  .char_valid      (char_valid),
  .char_perr       (char_perr),
  .err_clr         (err_clr),
  .push_ok         (push_ok),
  .pop_ok          (pop_ok),
  .drop            (drop),
  .tout_hit        (tout_hit),
  .cfg_rda_ie      (cfg_rda_ie),
  .cfg_tout_cnt_en (cfg_tout_cnt_en),
  .st_level        (st_level),
  .st_empty        (st_empty),
  .st_full         (st_full),
  .st_err          (st_err),
  .irq_rda         (irq_rda),
  .irq_tout        (irq_tout)
);

// File: tb/uart_rx_queue_bench.sv
module uart_rx_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int TW    = 8;
  localparam int LW    = 6;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst_n;
  logic          bit_tick, char_valid, char_perr, char_ferr, char_brk, rd_en, flush;
  logic [7:0]    char_data, rd_data;
  logic          rd_perr, rd_ferr, rd_brk;
  logic [3:0]    err_clr, cfg_trig_code, st_err;
  logic          cfg_rda_ie, cfg_tout_ie, cfg_tout_cnt_en;
  logic [TW-1:0] cfg_tout_limit;
  logic          st_empty, st_full, irq_rda, irq_tout;
  logic [LW-1:0] st_level;

  uart_rx_queue #(.DEPTH(DEPTH), .DATA_W(8), .TOUT_W(TW)) u_uart_rx_queue (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_valid(char_valid),
    .char_data(char_data), .char_perr(char_perr), .char_ferr(char_ferr),
    .char_brk(char_brk), .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .rd_brk(rd_brk), .flush(flush), .err_clr(err_clr),
    .cfg_trig_code(cfg_trig_code), .cfg_rda_ie(cfg_rda_ie), .cfg_tout_ie(cfg_tout_ie),
    .cfg_tout_cnt_en(cfg_tout_cnt_en), .cfg_tout_limit(cfg_tout_limit),
    .st_empty(st_empty), .st_full(st_full), .st_level(st_level), .st_err(st_err),
    .irq_rda(irq_rda), .irq_tout(irq_tout)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Reference state, kept from the requirements.
  logic [10:0] mq[$];
  logic [3:0]  m_err = 4'h0;
  int          m_cnt = 0;
  bit          m_flag = 0;

  function automatic int exp_trig(input logic [3:0] c);
    if (c == 4'd0) return 1;
    if (c == 4'd1) return 4;
    if (c == 4'd2) return 8;
    if (c == 4'd3) return 14;
    return 30;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    char_valid = 0; rd_en = 0; flush = 0; err_clr = 4'h0; bit_tick = 0;
    char_perr = 0; char_ferr = 0; char_brk = 0;
  endtask

  task automatic step(input string ctx);
    int sz;
    bit p_ok, r_ok, lost, ne, nflag;
    int ncnt;
    logic [3:0] nerr;
    sz    = mq.size();
    ne    = (sz > 0);
    p_ok  = char_valid && !flush && (sz < DEPTH);
    lost  = char_valid && !flush && (sz == DEPTH);
    r_ok  = rd_en && !flush && ne;
    if (flush || p_ok || r_ok || !ne || !cfg_tout_cnt_en) ncnt = 0;
    else if (bit_tick && !m_flag) ncnt = m_cnt + 1;
    else ncnt = m_cnt;
    if (r_ok || flush || !ne) nflag = 0;
    else if (cfg_tout_cnt_en && bit_tick && !m_flag && !p_ok && (m_cnt + 1 >= int'(cfg_tout_limit))) nflag = 1;
    else nflag = m_flag;
    nerr = (m_err & ~err_clr) | {lost, p_ok && char_brk, p_ok && char_ferr, p_ok && char_perr};
    @(posedge clk);
    if (flush) mq.delete();
    else begin
      if (r_ok) void'(mq.pop_front());
      if (p_ok) mq.push_back({char_brk, char_ferr, char_perr, char_data});
    end
    m_cnt = ncnt; m_flag = nflag; m_err = nerr;
    @(negedge clk);
    chk({ctx, " R1 level"}, 32'(st_level), mq.size());
    chk({ctx, " R1 empty"}, 32'(st_empty), 32'(mq.size() == 0));
    chk({ctx, " R1 full"}, 32'(st_full), 32'(mq.size() == DEPTH));
    if (mq.size() > 0) begin
      chk({ctx, " R1 head data"}, 32'(rd_data), 32'(mq[0][7:0]));
      chk({ctx, " R5 head tags"}, 32'({rd_brk, rd_ferr, rd_perr}), 32'(mq[0][10:8]));
    end
    chk({ctx, " R5 error bits"}, 32'(st_err[2:0]), 32'(m_err[2:0]));
    chk({ctx, " R2 overflow bit"}, 32'(st_err[3]), 32'(m_err[3]));
    chk({ctx, " R4 irq_rda"}, 32'(irq_rda), 32'(cfg_rda_ie && (mq.size() >= exp_trig(cfg_trig_code))));
    chk({ctx, " R7 irq_tout"}, 32'(irq_tout), 32'(cfg_tout_ie && m_flag));
  endtask

  task automatic send(input logic [7:0] d, input logic [2:0] tags, input string ctx);
    char_valid = 1; char_data = d; {char_brk, char_ferr, char_perr} = tags;
    step(ctx);
    char_valid = 0; {char_brk, char_ferr, char_perr} = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL R11 watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 0; idle(); char_data = 8'h00;
    cfg_trig_code = 4'd0; cfg_rda_ie = 1; cfg_tout_ie = 1; cfg_tout_cnt_en = 1;
    cfg_tout_limit = 8'd40;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk("R11 level", 32'(st_level), 0);
    chk("R11 empty", 32'(st_empty), 1);
    chk("R11 full", 32'(st_full), 0);
    chk("R11 sticky", 32'(st_err), 0);
    chk("R11 irqs", 32'({irq_rda, irq_tout}), 0);

    // R3: read on empty
    rd_en = 1; step("R3 read empty"); idle();
    chk("R3 still empty", 32'(st_level), 0);

    // R1/R2: fill, overflow, overflow with read
    cfg_trig_code = 4'd4;
    for (int i = 0; i < DEPTH; i++) send(8'(i * 7 + 3), 3'(i % 3 == 0 ? 0 : 0), "R1 fill");
    chk("R1 full after 32", 32'(st_full), 1);
    send(8'hEE, 3'b000, "R2 overflow");
    char_valid = 1; char_data = 8'hDD; rd_en = 1; step("R2 full with read"); idle();
    chk("R2 level after read on full", 32'(st_level), DEPTH - 1);
    err_clr = 4'b1000; step("R6 clear overflow"); idle();
    for (int i = 0; i < DEPTH; i++) begin rd_en = 1; step("R1 drain"); end
    idle();

    // R4: every trigger code against a rising level
    for (int c = 0; c < 16; c++) begin
      cfg_trig_code = 4'(c); cfg_rda_ie = (c != 9);
      flush = 1; step("R10 flush"); idle();
      for (int i = 0; i < 31; i++) send(8'(c * 16 + i), 3'b000, "R4 sweep");
    end
    cfg_rda_ie = 1; cfg_trig_code = 4'd2;

    // R5/R6: tags and write-one-to-clear
    flush = 1; step("R10 flush"); idle();
    send(8'h41, 3'b001, "R5 parity tag");
    send(8'h42, 3'b110, "R5 break+frame tag");
    err_clr = 4'b0001; send(8'h43, 3'b001, "R6 set wins");
    chk("R6 parity kept", 32'(st_err[0]), 1);
    err_clr = 4'b0111; step("R6 clear"); idle();
    chk("R6 cleared", 32'(st_err[2:0]), 0);
    rd_en = 1; step("R5 tag advance"); idle();

    // R7/R8/R9: idle timeout
    flush = 1; step("R10 flush"); idle();
    cfg_tout_limit = 8'd5; cfg_tout_cnt_en = 1; cfg_tout_ie = 1;
    send(8'h51, 3'b000, "R7 first char");
    for (int i = 0; i < 7; i++) begin bit_tick = 1; step("R7 ticking"); end
    idle();
    chk("R7 flag after limit", 32'(irq_tout), 1);
    send(8'h52, 3'b000, "R8 arrival keeps flag");
    for (int i = 0; i < 3; i++) begin bit_tick = 1; step("R8 ticking"); end
    rd_en = 1; step("R8 read clears"); idle();
    chk("R8 cleared by read", 32'(irq_tout), 0);
    for (int i = 0; i < 4; i++) begin bit_tick = 1; step("R8 restart count"); end
    idle();
    chk("R8 not yet after 4", 32'(irq_tout), 0);
    bit_tick = 1; step("R7 fifth tick"); idle();
    chk("R7 set on fifth", 32'(irq_tout), 1);
    rd_en = 1; step("R8 read"); idle();
    cfg_tout_cnt_en = 0; send(8'h53, 3'b000, "R9 char");
    for (int i = 0; i < 20; i++) begin bit_tick = 1; step("R9 disabled"); end
    idle();
    chk("R9 no flag", 32'(irq_tout), 0);
    cfg_tout_cnt_en = 1; cfg_tout_limit = 8'd0;
    bit_tick = 1; step("R7 limit zero"); idle();
    chk("R7 zero limit", 32'(irq_tout), 1);

    // R10: flush with simultaneous traffic
    for (int i = 0; i < 10; i++) send(8'(i), 3'b001, "R10 fill");
    flush = 1; char_valid = 1; char_data = 8'h99; rd_en = 1; step("R10 flush busy"); idle();
    chk("R10 empty", 32'(st_empty), 1);
    chk("R10 sticky kept", 32'(st_err[0]), 1);

    // Random traffic in write-heavy and read-heavy phases
    for (int blk = 0; blk < 10; blk++) begin
      cfg_trig_code   = 4'($urandom_range(0, 15));
      cfg_rda_ie      = 1'($urandom_range(0, 1));
      cfg_tout_ie     = 1'($urandom_range(0, 1));
      cfg_tout_cnt_en = ($urandom_range(0, 3) != 0);
      cfg_tout_limit  = 8'($urandom_range(0, 6));
      for (int i = 0; i < 400; i++) begin
        char_valid = ($urandom_range(0, 99) < ((blk % 2 == 1) ? 30 : 70));
        char_data  = 8'($urandom);
        {char_brk, char_ferr, char_perr} = ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'b000;
        rd_en      = ($urandom_range(0, 99) < ((blk % 2 == 1) ? 70 : 30));
        bit_tick   = ($urandom_range(0, 3) == 0);
        flush      = ($urandom_range(0, 199) == 0);
        err_clr    = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'h0;
        step("random");
      end
      idle();
    end

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule